// File: doc/BRIEF.md
# Programmable High/Low Clock Channel Divider

This block divides a fast input clock into a channel clock whose high time and low time are programmed separately, each by a 4-bit count. A small register-style configuration bus sets those counts and several control bits. The bit selecting the level of the first phase, a phase delay applied when the chip-level synchronization input is released, and a mask that makes the channel ignore synchronization. The bus also sets a static-high override that is honoured only while synchronization is masked, a bypass that routes the input clock straight to the output, and a power-down that silences the channel and drops its output enable.

Writes land in a shadow copy at once and can be read back on the same bus. The counting logic takes a new shadow copy only at safe points, so a running output never shows a shortened pulse. Those points are: while synchronization or power-down holds the channel, on every cycle of bypass or static mode, and at the edge that completes a full high-plus-low period. A duty-cycle-correction disable bit is kept for read-back only.

Top module: `clk_chan_div`

## Requirements
- R1: After reset every configuration field reads 0, the output enable is 1, and with synchronization released the output toggles on every rising input edge (one cycle high, one cycle low).
- R2: While running, the output stays high for H+1 input cycles and low for L+1 input cycles, where H is bits [7:4] and L is bits [3:0] of address 0.
- R3: While sync_ni is 0 and the ignore bit (address 1 bit 1) is 0, the counters are cleared and the output sits at the start level (address 1 bit 3: 1 = high, 0 = low).
- R4: Let E0 be the first rising edge at which sync_ni is sampled 1 after a hold. The output keeps the start level through edge E0+P+D-1 and changes at edge E0+P+D. Here P is the phase field (address 1 bits [7:4]) and D is the start level's duration (H+1 or L+1).
- R5: With the ignore bit set, sync_ni has no effect on the output.
- R6: With both the ignore bit and the force bit (address 1 bit 2) in effect, the output is static high. A force bit with the ignore bit clear has no effect.
- R7: With the bypass bit (address 1 bit 0) in effect, clk_o equals clk_i.
- R8: While the power-down bit (address 2 bit 0) is 1, clk_o is 0 and oe_o is 0 from the edge of the write. On leaving power-down, oe_o returns to 1 and the divider restarts exactly as after a synchronization release.
- R9: A shadow change reaches the counters only during a hold, during bypass or static mode, or at the edge where the output returns to the start level after a full period. No pulse of a running output is ever shortened.
- R10: The correction-disable bit (address 2 bit 1) is stored and read back but does not change the output.
- R11: A write with cfg_we_i high is captured at the rising edge. cfg_rdata_o combinationally returns the addressed register: address 0 = {H,L}, address 1 = {P, start, force, ignore, bypass}, address 2 = {6'b0, correction-disable, power-down}, and address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sync_ni | input | 1 | Chip-level synchronization, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 2 | Configuration register address |
| cfg_wdata_i | input | 8 | Configuration write data |
| cfg_rdata_o | output | 8 | Read-back of the addressed register |
| clk_o | output | 1 | Divided (or bypassed) channel clock |
| oe_o | output | 1 | Output enable, low in power-down |

## Verification
A register write lands in the shadow at the edge that captures it. Read-back is therefore valid right after that edge, and power-down and its enable drop are visible one edge after the write. Count changes reach the waveform only at the next full-period boundary. After a synchronization release, the first level change falls P+D edges after E0. The bench keeps a behavioural model that advances on the same rising edge and compares clk_o and oe_o a quarter period after every edge, where all those results have settled. Bypass is also checked half a period later, so that both clock levels are seen.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;

    parameter int CNT_W  = 4;
    parameter int DATA_W = 8;
    parameter int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_COUNTS = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_MODE   = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_POWER  = ADDR_W'(2);

    typedef struct packed {
        logic [CNT_W-1:0] phase;
        logic             start_hi;
        logic             force_hi;
        logic             ign_sync;
        logic             bypass;
        logic [CNT_W-1:0] hi_cnt;
        logic [CNT_W-1:0] lo_cnt;
        logic             dcc_off;
        logic             pwrdn;
    } cdiv_cfg_t;

    typedef enum logic {
        M_HOLD = 1'b0,
        M_RUN  = 1'b1
    } cdiv_mode_e;

endpackage

// File: rtl/cdiv_regs.sv
module cdiv_regs
    import cdiv_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output cdiv_cfg_t         cfg_o
);

    localparam int PAD_W = DATA_W - 2;

    cdiv_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we_i) begin
            unique case (addr_i)
                A_COUNTS: begin
                    cfg_d.hi_cnt = wdata_i[2*CNT_W-1:CNT_W];
                    cfg_d.lo_cnt = wdata_i[CNT_W-1:0];
                end
                A_MODE: begin
                    cfg_d.phase    = wdata_i[2*CNT_W-1:CNT_W];
                    cfg_d.start_hi = wdata_i[3];
                    cfg_d.force_hi = wdata_i[2];
                    cfg_d.ign_sync = wdata_i[1];
                    cfg_d.bypass   = wdata_i[0];
                end
                A_POWER: begin
                    cfg_d.dcc_off = wdata_i[1];
                    cfg_d.pwrdn   = wdata_i[0];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cfg_q <= '0;
        else         cfg_q <= cfg_d;
    end

    always_comb begin
        unique case (addr_i)
            A_COUNTS: rdata_o = {cfg_q.hi_cnt, cfg_q.lo_cnt};
            A_MODE:   rdata_o = {cfg_q.phase, cfg_q.start_hi, cfg_q.force_hi,
                                 cfg_q.ign_sync, cfg_q.bypass};
            A_POWER:  rdata_o = {{PAD_W{1'b0}}, cfg_q.dcc_off, cfg_q.pwrdn};
            default:  rdata_o = '0;
        endcase
    end

    assign cfg_o = cfg_q;

endmodule

// File: rtl/cdiv_core.sv
module cdiv_core
    import cdiv_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      sync_ni,
    input  cdiv_cfg_t sh_i,
    output logic      lvl_o,
    output logic      bypass_o,
    output logic      forced_o
);

    typedef struct packed {
        cdiv_cfg_t        act;
        cdiv_mode_e       mode;
        logic             lvl;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] wcnt;
    } core_st_t;

    core_st_t st_d, st_q;

    logic             hold;
    logic             idle;
    logic [CNT_W-1:0] dur_m1;

    assign hold   = sh_i.pwrdn || (!sync_ni && !sh_i.ign_sync);
    assign idle   = st_q.act.bypass || (st_q.act.ign_sync && st_q.act.force_hi);
    assign dur_m1 = st_q.lvl ? st_q.act.hi_cnt : st_q.act.lo_cnt;

    always_comb begin
        st_d = st_q;
        if (hold || idle) begin
            st_d.act  = sh_i;
            st_d.mode = M_HOLD;
            st_d.lvl  = sh_i.start_hi;
            st_d.cnt  = '0;
            st_d.wcnt = '0;
        end else if (st_q.mode == M_HOLD) begin
            st_d.mode = M_RUN;
            st_d.wcnt = st_q.act.phase;
            st_d.cnt  = '0;
        end else if (st_q.wcnt != '0) begin
            st_d.wcnt = st_q.wcnt - 1'b1;
        end else if (st_q.cnt == dur_m1) begin
            st_d.lvl = !st_q.lvl;
            st_d.cnt = '0;
            if (st_q.lvl != st_q.act.start_hi) begin
                st_d.act = sh_i;
            end
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign lvl_o    = st_q.lvl;
    assign bypass_o = st_q.act.bypass;
    assign forced_o = st_q.act.ign_sync && st_q.act.force_hi;

endmodule

// File: rtl/cdiv_outmux.sv
module cdiv_outmux (
    input  logic clk_i,
    input  logic pwrdn_i,
    input  logic bypass_i,
    input  logic forced_i,
    input  logic lvl_i,
    output logic clk_o,
    output logic oe_o
);

    always_comb begin
        if (pwrdn_i)       clk_o = 1'b0;
        else if (bypass_i) clk_o = clk_i;
        else if (forced_i) clk_o = 1'b1;
        else               clk_o = lvl_i;
    end

    assign oe_o = !pwrdn_i;

endmodule

// File: rtl/clk_chan_div.sv
module clk_chan_div
    import cdiv_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              sync_ni,
    input  logic              cfg_we_i,
    input  logic [ADDR_W-1:0] cfg_addr_i,
    input  logic [DATA_W-1:0] cfg_wdata_i,
    output logic [DATA_W-1:0] cfg_rdata_o,
    output logic              clk_o,
    output logic              oe_o
);

    cdiv_cfg_t sh_cfg;
    logic      core_lvl;
    logic      core_bypass;
    logic      core_forced;

    cdiv_regs u_regs (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (cfg_we_i),
        .addr_i  (cfg_addr_i),
        .wdata_i (cfg_wdata_i),
        .rdata_o (cfg_rdata_o),
        .cfg_o   (sh_cfg)
    );

    cdiv_core u_core (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .sync_ni  (sync_ni),
        .sh_i     (sh_cfg),
        .lvl_o    (core_lvl),
        .bypass_o (core_bypass),
        .forced_o (core_forced)
    );

    cdiv_outmux u_out (
        .clk_i    (clk_i),
        .pwrdn_i  (sh_cfg.pwrdn),
        .bypass_i (core_bypass),
        .forced_i (core_forced),
        .lvl_i    (core_lvl),
        .clk_o    (clk_o),
        .oe_o     (oe_o)
    );

endmodule

// File: rtl/clk_chan_div_chk.sv
module clk_chan_div_chk
    import cdiv_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic              sync_ni,
    input logic              cfg_we_i,
    input logic [ADDR_W-1:0] cfg_addr_i,
    input logic [DATA_W-1:0] cfg_wdata_i,
    input logic [DATA_W-1:0] cfg_rdata_o,
    input logic              clk_o,
    input logic              oe_o,
    input cdiv_cfg_t         sh_cfg
);

    // R3
    sync_hold_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(!sync_ni && !sh_cfg.ign_sync && !sh_cfg.pwrdn) && $stable(sh_cfg)
         && !sh_cfg.bypass && !sh_cfg.pwrdn)
        |-> (clk_o == sh_cfg.start_hi));

    // R8
    pwrdn_enter_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_we_i && cfg_addr_i == A_POWER && cfg_wdata_i[0]) |=> (!oe_o && !clk_o));

    // R8
    pwrdn_leave_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_we_i && cfg_addr_i == A_POWER && !cfg_wdata_i[0]) |=> oe_o);

    // R11
    counts_readback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(cfg_we_i && cfg_addr_i == A_COUNTS) && cfg_addr_i == A_COUNTS)
        |-> (cfg_rdata_o == $past(cfg_wdata_i)));

    // R11
    mode_readback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(cfg_we_i && cfg_addr_i == A_MODE) && cfg_addr_i == A_MODE)
        |-> (cfg_rdata_o == $past(cfg_wdata_i)));

    // R10
    power_readback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(cfg_we_i && cfg_addr_i == A_POWER) && cfg_addr_i == A_POWER)
        |-> (cfg_rdata_o[1:0] == $past(cfg_wdata_i[1:0]) && cfg_rdata_o[DATA_W-1:2] == '0));

endmodule

bind clk_chan_div clk_chan_div_chk u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sync_ni     (sync_ni),
    .cfg_we_i    (cfg_we_i),
    .cfg_addr_i  (cfg_addr_i),
    .cfg_wdata_i (cfg_wdata_i),
    .cfg_rdata_o (cfg_rdata_o),
    .clk_o       (clk_o),
    .oe_o        (oe_o),
    .sh_cfg      (sh_cfg)
);

// File: tb/clk_chan_div_bench.sv
module clk_chan_div_bench;

    localparam int CLK_T = 8;

    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic       sync_ni = 1'b1;
    logic       cfg_we_i = 1'b0;
    logic [1:0] cfg_addr_i = 2'd0;
    logic [7:0] cfg_wdata_i = 8'h00;
    logic [7:0] cfg_rdata_o;
    logic       clk_o;
    logic       oe_o;

    int    checks = 0;
    int    failures = 0;
    bit    cmp_en = 1'b0;
    bit    done = 1'b0;
    string tag = "R1";

    clk_chan_div u_clk_chan_div (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .sync_ni     (sync_ni),
        .cfg_we_i    (cfg_we_i),
        .cfg_addr_i  (cfg_addr_i),
        .cfg_wdata_i (cfg_wdata_i),
        .cfg_rdata_o (cfg_rdata_o),
        .clk_o       (clk_o),
        .oe_o        (oe_o)
    );

    always #(CLK_T/2) clk_i = ~clk_i;

    // behavioural reference: shadow fields s_*, applied fields a_*
    int s_hi, s_lo, s_ph, s_st, s_frc, s_ign, s_byp, s_pd, s_dcc;
    int a_hi, a_lo, a_ph, a_st, a_frc, a_ign, a_byp;
    int m_run, m_lvl, m_rem, m_wait;

    task automatic take_shadow();
        a_hi = s_hi; a_lo = s_lo; a_ph = s_ph; a_st = s_st;
        a_frc = s_frc; a_ign = s_ign; a_byp = s_byp;
    endtask

    function automatic int span(int level);
        return level != 0 ? a_hi + 1 : a_lo + 1;
    endfunction

    always @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_hi = 0; s_lo = 0; s_ph = 0; s_st = 0; s_frc = 0; s_ign = 0;
            s_byp = 0; s_pd = 0; s_dcc = 0;
            take_shadow();
            m_run = 0; m_lvl = 0; m_rem = 0; m_wait = 0;
        end else begin
            if (s_pd != 0 || (!sync_ni && s_ign == 0) || a_byp != 0 ||
                (a_ign != 0 && a_frc != 0)) begin
                take_shadow();
                m_run = 0; m_lvl = s_st; m_rem = 0; m_wait = 0;
            end else if (m_run == 0) begin
                m_run = 1; m_wait = a_ph; m_rem = span(m_lvl);
            end else if (m_wait > 0) begin
                m_wait = m_wait - 1;
            end else begin
                m_rem = m_rem - 1;
                if (m_rem == 0) begin
                    bit back_to_start;
                    back_to_start = (m_lvl != a_st);
                    m_lvl = 1 - m_lvl;
                    if (back_to_start) take_shadow();
                    m_rem = span(m_lvl);
                end
            end
            if (cfg_we_i) begin
                case (cfg_addr_i)
                    2'd0: begin s_hi = int'(cfg_wdata_i[7:4]); s_lo = int'(cfg_wdata_i[3:0]); end
                    2'd1: begin
                        s_ph = int'(cfg_wdata_i[7:4]); s_st = int'(cfg_wdata_i[3]);
                        s_frc = int'(cfg_wdata_i[2]); s_ign = int'(cfg_wdata_i[1]);
                        s_byp = int'(cfg_wdata_i[0]);
                    end
                    2'd2: begin s_dcc = int'(cfg_wdata_i[1]); s_pd = int'(cfg_wdata_i[0]); end
                    default: ;
                endcase
            end
        end
    end

    function automatic logic exp_clk();
        if (s_pd != 0)                  return 1'b0;
        if (a_byp != 0)                 return clk_i;
        if (a_ign != 0 && a_frc != 0)   return 1'b1;
        return m_lvl != 0;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk_i) begin
        if (cmp_en) begin
            #2;
            chk({tag, " clk_o"}, int'(clk_o), int'(exp_clk()));
            chk({tag, " oe_o"}, int'(oe_o), (s_pd == 0) ? 1 : 0);
        end
    end

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk_i);
        cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
        @(negedge clk_i);
        cfg_we_i = 1'b0;
    endtask

    task automatic rd_chk(string req, logic [1:0] a, logic [7:0] exp);
        @(negedge clk_i);
        cfg_addr_i = a;
        #1;
        chk(req, int'(cfg_rdata_o), int'(exp));
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk_i);
    endtask

    initial begin
        repeat (50000) @(posedge clk_i);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int toggles;
        logic prev;
        repeat (4) @(negedge clk_i);
        rst_ni = 1'b1;
        cmp_en = 1'b1;

        tag = "R1";
        rd_chk("R1 counts after reset", 2'd0, 8'h00);
        rd_chk("R1 mode after reset", 2'd1, 8'h00);
        rd_chk("R1 power after reset", 2'd2, 8'h00);
        wait_cyc(10);

        tag = "R2";
        wr(2'd0, 8'h20); wait_cyc(40);
        wr(2'd0, 8'h05); wait_cyc(40);
        wr(2'd0, 8'h00); wait_cyc(6);

        tag = "R9";
        wr(2'd0, 8'hFF); wait_cyc(3);
        wr(2'd0, 8'h31); wait_cyc(80);
        wr(2'd0, 8'h12); wait_cyc(30);

        tag = "R3";
        wr(2'd1, 8'h08);
        @(negedge clk_i) sync_ni = 1'b0;
        wait_cyc(6);
        tag = "R4";
        wr(2'd1, 8'h38); wait_cyc(2);
        @(negedge clk_i) sync_ni = 1'b1;
        wait_cyc(30);
        wr(2'd1, 8'hF0);
        @(negedge clk_i) sync_ni = 1'b0;
        wait_cyc(3);
        @(negedge clk_i) sync_ni = 1'b1;
        wait_cyc(50);

        tag = "R5";
        wr(2'd1, 8'h02); wait_cyc(10);
        @(negedge clk_i) sync_ni = 1'b0;
        toggles = 0; prev = clk_o;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk_i);
            if (clk_o != prev) toggles++;
            prev = clk_o;
        end
        chk("R5 output keeps toggling under masked sync", (toggles > 0) ? 1 : 0, 1);
        @(negedge clk_i) sync_ni = 1'b1;
        wait_cyc(10);

        tag = "R6";
        wr(2'd1, 8'h04); wait_cyc(20);
        wr(2'd1, 8'h06); wait_cyc(10);
        toggles = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk_i);
            if (clk_o != 1'b1) toggles++;
        end
        chk("R6 static high samples off", toggles, 0);
        wr(2'd1, 8'h00); wait_cyc(20);

        tag = "R7";
        wr(2'd1, 8'h01); wait_cyc(5);
        @(negedge clk_i); #2;
        chk("R7 bypass low half", int'(clk_o), 0);
        @(posedge clk_i); #2;
        chk("R7 bypass high half", int'(clk_o), 1);
        wr(2'd1, 8'h00); wait_cyc(20);

        tag = "R8";
        wr(2'd0, 8'h11);
        wr(2'd2, 8'h01); wait_cyc(5);
        chk("R8 power-down clk_o", int'(clk_o), 0);
        chk("R8 power-down oe_o", int'(oe_o), 0);
        @(negedge clk_i) sync_ni = 1'b0;
        wait_cyc(3);
        @(negedge clk_i) sync_ni = 1'b1;
        wr(2'd2, 8'h00); wait_cyc(30);

        tag = "R10";
        wr(2'd2, 8'h02);
        rd_chk("R10 correction bit read-back", 2'd2, 8'h02);
        wait_cyc(30);

        tag = "R11";
        wr(2'd1, 8'h5A);
        rd_chk("R11 mode read-back", 2'd1, 8'h5A);
        wr(2'd0, 8'hC3);
        rd_chk("R11 counts read-back", 2'd0, 8'hC3);
        wr(2'd3, 8'hFF);
        rd_chk("R11 unused address reads zero", 2'd3, 8'h00);
        wait_cyc(40);

        cmp_en = 1'b0;
        done = 1'b1;
        @(negedge clk_i);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule